// File: doc/BRIEF.md
# Memory Epoch Invariant Verifier

This block sits beside a home memory controller and audits the coherence history of the blocks homed there. Each cache controller reports an epoch when the epoch ends. An epoch is an interval of logical time in which one cache held a block with either shared (read-only) or exclusive (writable) permission. A report carries the block index, the epoch type, its start and end logical times, and compact hashes of the block data at the start and at the end of the epoch.

Reports can arrive in any order. They are first held in a small sorting buffer, and the buffer releases them one at a time, lowest start time first. Each released report is checked against a per-block table. A table entry holds three values: the latest end time of any shared epoch, the latest end time of any exclusive epoch, and the data hash left by the most recent exclusive epoch. The check flags two faults. One is an epoch that overlaps an exclusive epoch, or an exclusive epoch that overlaps any earlier epoch. The other is an epoch whose starting data does not match what the last writer left behind. Reports that pass update the table. Reports that fail leave it unchanged.

The verdict for each report appears one cycle after the report leaves the buffer. If the buffer is too small for the real reordering in the system, an out-of-order release can raise a false error.

Top module: `epoch_verifier`

## Requirements
- R1: After reset every table entry holds end times of 0 and the hash ZERO_HASH (default 16'h1D0F), and out_valid is 0 until a report is released.
- R2: The sorting buffer releases the held report with the smallest start time.
- R3: The buffer releases one report in any cycle in which it holds DEPTH (8) reports, or in which flush is 1 and it is not empty. A report pushed in the same cycle is still accepted. The verdict appears on the outputs in the cycle after the release.
- R4: A shared report (in_excl=0) whose start time is below the stored exclusive end time sets out_err_overlap.
- R5: An exclusive report (in_excl=1) whose start time is below either the stored shared end time or the stored exclusive end time sets out_err_overlap.
- R6: A report whose start hash differs from the stored hash sets out_err_hash.
- R7: A shared report with no error sets the stored shared end time to the larger of its old value and the report's end time.
- R8: An exclusive report with no error replaces the stored exclusive end time with the report's end time and the stored hash with the report's end hash.
- R9: A report that raises either error leaves the table entry unchanged.
- R10: Table entries of different blocks are independent.
- R11: flush with an empty buffer produces no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Epoch report present this cycle |
| in_block | input | 4 | Block index of the report |
| in_excl | input | 1 | 1 = exclusive epoch, 0 = shared epoch |
| in_start | input | 16 | Logical start time |
| in_end | input | 16 | Logical end time |
| in_start_hash | input | 16 | Data hash at epoch start |
| in_end_hash | input | 16 | Data hash at epoch end |
| flush | input | 1 | Release one report even if the buffer is not full |
| out_valid | output | 1 | Verdict for one report |
| out_block | output | 4 | Block index of the checked report |
| out_excl | output | 1 | Type of the checked report |
| out_start | output | 16 | Start time of the checked report |
| out_err_overlap | output | 1 | Epoch overlap violation |
| out_err_hash | output | 1 | Data hand-off violation |

## Verification
The hardest case to reach is the automatic release from a full buffer while a new report is pushed in the same cycle. To reach it, the stimulus fills the buffer with eight reports in falling time order and then pushes a ninth report that is earlier than all of them. The bench expects the eighth-oldest report first, then the new one, then the rest in ascending order. It also expects the freed slot to have taken the new report without loss. Proving that a failed report left the table untouched needs a follow-on report whose verdict depends on the old value. After a rejected shared report with a late end time, an exclusive report that starts after the earlier shared end must still pass.

// File: rtl/epv_pkg.sv
package epv_pkg;
  parameter int EPV_TIME_W = 16;
  parameter int EPV_HASH_W = 16;
  parameter int EPV_BLK_W  = 4;

  typedef struct packed {
    logic [EPV_BLK_W-1:0]  blk;
    logic                  excl;
    logic [EPV_TIME_W-1:0] t_start;
    logic [EPV_TIME_W-1:0] t_end;
    logic [EPV_HASH_W-1:0] h_start;
    logic [EPV_HASH_W-1:0] h_end;
  } epv_rpt_t;
endpackage

// File: rtl/epv_sort_buf.sv
module epv_sort_buf
  import epv_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     push,
  input  epv_rpt_t push_rpt,
  input  logic     flush,
  output logic     pop,
  output epv_rpt_t pop_rpt
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  epv_rpt_t             slot_q [DEPTH];
  epv_rpt_t             slot_d [DEPTH];
  logic [DEPTH-1:0]     vld_q, vld_d;
  logic [CNT_W-1:0]     cnt_q, cnt_d;
  logic [IDX_W-1:0]     min_idx, free_idx, ins_idx;
  logic                 full;

  assign full = (cnt_q == CNT_W'(DEPTH));
  assign pop  = full || (flush && (cnt_q != '0));

  // smallest start time among held reports; lowest slot wins ties
  always_comb begin
    logic found;
    found   = 1'b0;
    min_idx = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (vld_q[i] && (!found || (slot_q[i].t_start < slot_q[min_idx].t_start))) begin
        min_idx = IDX_W'(i);
        found   = 1'b1;
      end
    end
  end

  always_comb begin
    logic found;
    found    = 1'b0;
    free_idx = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!vld_q[i] && !found) begin
        free_idx = IDX_W'(i);
        found    = 1'b1;
      end
    end
  end

  assign ins_idx = full ? min_idx : free_idx;
  assign pop_rpt = slot_q[min_idx];

  always_comb begin
    vld_d = vld_q;
    for (int i = 0; i < DEPTH; i++) slot_d[i] = slot_q[i];
    if (pop) vld_d[min_idx] = 1'b0;
    if (push) begin
      vld_d[ins_idx]  = 1'b1;
      slot_d[ins_idx] = push_rpt;
    end
    cnt_d = cnt_q + CNT_W'(push) - CNT_W'(pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      cnt_q <= '0;
    end else begin
      vld_q <= vld_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) slot_q[i] <= slot_d[i];
  end

  assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));

  assert_no_pop_empty_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0) |-> !pop);
endmodule

// File: rtl/epv_table.sv
module epv_table
  import epv_pkg::*;
#(
  parameter int                  NBLK      = 16,
  parameter logic [EPV_HASH_W-1:0] ZERO_HASH = 16'h1D0F
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [EPV_BLK_W-1:0]  rd_blk,
  output logic [EPV_TIME_W-1:0] rd_sh_end,
  output logic [EPV_TIME_W-1:0] rd_ex_end,
  output logic [EPV_HASH_W-1:0] rd_hash,
  input  logic                  wr_sh,
  input  logic                  wr_ex,
  input  logic [EPV_BLK_W-1:0]  wr_blk,
  input  logic [EPV_TIME_W-1:0] wr_time,
  input  logic [EPV_HASH_W-1:0] wr_hash
);
  logic [EPV_TIME_W-1:0] sh_q [NBLK];
  logic [EPV_TIME_W-1:0] ex_q [NBLK];
  logic [EPV_HASH_W-1:0] hs_q [NBLK];

  assign rd_sh_end = sh_q[rd_blk];
  assign rd_ex_end = ex_q[rd_blk];
  assign rd_hash   = hs_q[rd_blk];

  for (genvar g = 0; g < NBLK; g++) begin : g_ent
    logic sel;
    assign sel = (wr_blk == EPV_BLK_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sh_q[g] <= '0;
        ex_q[g] <= '0;
        hs_q[g] <= ZERO_HASH;
      end else begin
        if (sel && wr_sh) sh_q[g] <= wr_time;
        if (sel && wr_ex) begin
          ex_q[g] <= wr_time;
          hs_q[g] <= wr_hash;
        end
      end
    end
  end

  assert_one_write_kind_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_sh && wr_ex));

  assert_sh_grows_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_sh |-> (wr_time >= sh_q[wr_blk]));
endmodule

// File: rtl/epv_check.sv
module epv_check
  import epv_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  pop,
  input  epv_rpt_t              rpt,
  input  logic [EPV_TIME_W-1:0] sh_end,
  input  logic [EPV_TIME_W-1:0] ex_end,
  input  logic [EPV_HASH_W-1:0] cur_hash,
  output logic                  wr_sh,
  output logic                  wr_ex,
  output logic [EPV_TIME_W-1:0] wr_time,
  output logic [EPV_HASH_W-1:0] wr_hash,
  output logic                  chk_valid,
  output logic [EPV_BLK_W-1:0]  chk_blk,
  output logic                  chk_excl,
  output logic [EPV_TIME_W-1:0] chk_start,
  output logic                  chk_ov,
  output logic                  chk_hs
);
  logic ov, hs, pass;
  logic                  v_d, x_d, ov_d, hs_d;
  logic [EPV_BLK_W-1:0]  b_d;
  logic [EPV_TIME_W-1:0] s_d;

  always_comb begin
    ov = (rpt.t_start < ex_end) || (rpt.excl && (rpt.t_start < sh_end));
    hs = (rpt.h_start != cur_hash);
    pass = !ov && !hs;
    wr_sh   = pop && !rpt.excl && pass;
    wr_ex   = pop && rpt.excl && pass;
    wr_time = rpt.excl ? rpt.t_end : ((rpt.t_end > sh_end) ? rpt.t_end : sh_end);
    wr_hash = rpt.h_end;
  end

  always_comb begin
    v_d  = pop;
    b_d  = pop ? rpt.blk     : chk_blk;
    x_d  = pop ? rpt.excl    : chk_excl;
    s_d  = pop ? rpt.t_start : chk_start;
    ov_d = pop && ov;
    hs_d = pop && hs;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_valid <= 1'b0;
      chk_blk   <= '0;
      chk_excl  <= 1'b0;
      chk_start <= '0;
      chk_ov    <= 1'b0;
      chk_hs    <= 1'b0;
    end else begin
      chk_valid <= v_d;
      chk_blk   <= b_d;
      chk_excl  <= x_d;
      chk_start <= s_d;
      chk_ov    <= ov_d;
      chk_hs    <= hs_d;
    end
  end

  assert_err_only_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_valid |-> !(chk_ov || chk_hs));
endmodule

// File: rtl/epoch_verifier.sv
module epoch_verifier
  import epv_pkg::*;
#(
  parameter int                    DEPTH     = 8,
  parameter int                    NBLK      = 16,
  parameter logic [EPV_HASH_W-1:0] ZERO_HASH = 16'h1D0F
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic [EPV_BLK_W-1:0]  in_block,
  input  logic                  in_excl,
  input  logic [EPV_TIME_W-1:0] in_start,
  input  logic [EPV_TIME_W-1:0] in_end,
  input  logic [EPV_HASH_W-1:0] in_start_hash,
  input  logic [EPV_HASH_W-1:0] in_end_hash,
  input  logic                  flush,
  output logic                  out_valid,
  output logic [EPV_BLK_W-1:0]  out_block,
  output logic                  out_excl,
  output logic [EPV_TIME_W-1:0] out_start,
  output logic                  out_err_overlap,
  output logic                  out_err_hash
);
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  epv_rpt_t              in_rpt, pop_rpt;
  logic                  pop, wr_sh, wr_ex;
  logic [EPV_TIME_W-1:0] sh_end, ex_end, wr_time;
  logic [EPV_HASH_W-1:0] cur_hash, wr_hash;

  assign in_rpt = '{blk: in_block, excl: in_excl, t_start: in_start,
                    t_end: in_end, h_start: in_start_hash, h_end: in_end_hash};

  epv_sort_buf #(.DEPTH(DEPTH)) u_sort (
    .clk(clk), .rst_n(rst_sync_q), .push(in_valid), .push_rpt(in_rpt),
    .flush(flush), .pop(pop), .pop_rpt(pop_rpt)
  );

  epv_table #(.NBLK(NBLK), .ZERO_HASH(ZERO_HASH)) u_tbl (
    .clk(clk), .rst_n(rst_sync_q), .rd_blk(pop_rpt.blk),
    .rd_sh_end(sh_end), .rd_ex_end(ex_end), .rd_hash(cur_hash),
    .wr_sh(wr_sh), .wr_ex(wr_ex), .wr_blk(pop_rpt.blk),
    .wr_time(wr_time), .wr_hash(wr_hash)
  );

  epv_check u_chk (
    .clk(clk), .rst_n(rst_sync_q), .pop(pop), .rpt(pop_rpt),
    .sh_end(sh_end), .ex_end(ex_end), .cur_hash(cur_hash),
    .wr_sh(wr_sh), .wr_ex(wr_ex), .wr_time(wr_time), .wr_hash(wr_hash),
    .chk_valid(out_valid), .chk_blk(out_block), .chk_excl(out_excl),
    .chk_start(out_start), .chk_ov(out_err_overlap), .chk_hs(out_err_hash)
  );

  assert_out_after_pop_R3: assert property (@(posedge clk) disable iff (!rst_sync_q)
    out_valid |-> $past(pop));
endmodule

// File: tb/tb_epoch_verifier.sv
module tb_epoch_verifier;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_excl, flush;
  logic [3:0]  in_block;
  logic [15:0] in_start, in_end, in_start_hash, in_end_hash;
  logic        out_valid, out_excl, out_err_overlap, out_err_hash;
  logic [3:0]  out_block;
  logic [15:0] out_start;
  int checks = 0;
  int errors = 0;
  localparam logic [15:0] ZH = 16'h1D0F;

  always #10 clk = ~clk;

  epoch_verifier dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_block(in_block),
    .in_excl(in_excl), .in_start(in_start), .in_end(in_end),
    .in_start_hash(in_start_hash), .in_end_hash(in_end_hash), .flush(flush),
    .out_valid(out_valid), .out_block(out_block), .out_excl(out_excl),
    .out_start(out_start), .out_err_overlap(out_err_overlap),
    .out_err_hash(out_err_hash)
  );

  task automatic expect_out(input string tag, input logic v, input logic [3:0] b,
                            input logic [15:0] s, input logic ov, input logic hs);
    checks++;
    if (out_valid !== v || (v && (out_block !== b || out_start !== s ||
        out_err_overlap !== ov || out_err_hash !== hs))) begin
      errors++;
      $display("FAIL %s: got v=%b blk=%0d start=%0d ov=%b hs=%b, expected v=%b blk=%0d start=%0d ov=%b hs=%b",
               tag, out_valid, out_block, out_start, out_err_overlap, out_err_hash,
               v, b, s, ov, hs);
    end
  endtask

  // drive at negedge, hold across one rising edge, return at next negedge
  task automatic push(input logic [3:0] b, input logic x, input logic [15:0] s,
                      input logic [15:0] e, input logic [15:0] hs, input logic [15:0] he);
    in_valid = 1'b1; in_block = b; in_excl = x; in_start = s; in_end = e;
    in_start_hash = hs; in_end_hash = he;
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic pop1();
    flush = 1'b1;
    @(posedge clk); @(negedge clk);
    flush = 1'b0;
  endtask

  task automatic t_reset();
    expect_out("R1 idle after reset", 1'b0, 0, 0, 0, 0);
    push(1, 0, 0, 10, ZH, ZH);
    expect_out("R3 no output on push alone", 1'b0, 0, 0, 0, 0);
    pop1();
    expect_out("R1 fresh entry zero time and zero hash", 1'b1, 1, 0, 0, 0);
    pop1();
    expect_out("R11 flush on empty buffer", 1'b0, 0, 0, 0, 0);
  endtask

  task automatic t_handoff();
    push(1, 1, 12, 20, ZH, 16'hBEEF); pop1();
    expect_out("R8 exclusive passes", 1'b1, 1, 12, 0, 0);
    push(1, 0, 25, 30, 16'hBEEF, 16'hBEEF); pop1();
    expect_out("R8 hash taken from exclusive end", 1'b1, 1, 25, 0, 0);
    push(1, 0, 22, 50, ZH, ZH); pop1();
    expect_out("R6 stale start hash", 1'b1, 1, 22, 0, 1);
  endtask

  task automatic t_overlap();
    push(1, 0, 18, 40, 16'hBEEF, 16'hBEEF); pop1();
    expect_out("R4 shared before exclusive end", 1'b1, 1, 18, 1, 0);
    push(1, 1, 29, 35, 16'hBEEF, 16'hCAFE); pop1();
    expect_out("R5 exclusive before shared end", 1'b1, 1, 29, 1, 0);
    push(1, 1, 31, 35, 16'hBEEF, 16'hCAFE); pop1();
    expect_out("R9 R7 failed reports left shared end at 30", 1'b1, 1, 31, 0, 0);
    push(1, 0, 35, 36, 16'hCAFE, 16'hCAFE); pop1();
    expect_out("R8 second hand-off", 1'b1, 1, 35, 0, 0);
    push(2, 1, 0, 3, ZH, 16'h0001); pop1();
    expect_out("R10 other block untouched", 1'b1, 2, 0, 0, 0);
  endtask

  task automatic t_sort();
    push(3, 0, 30, 31, ZH, ZH);
    push(3, 0, 10, 11, ZH, ZH);
    push(3, 0, 20, 21, ZH, ZH);
    pop1(); expect_out("R2 first smallest", 1'b1, 3, 10, 0, 0);
    pop1(); expect_out("R2 second", 1'b1, 3, 20, 0, 0);
    pop1(); expect_out("R2 third", 1'b1, 3, 30, 0, 0);
    pop1(); expect_out("R11 drained", 1'b0, 0, 0, 0, 0);
  endtask

  task automatic t_full();
    for (int i = 8; i >= 1; i--) begin
      push(4, 0, 16'(i * 10), 16'(i * 10 + 5), ZH, ZH);
      expect_out("R3 no release below full", 1'b0, 0, 0, 0, 0);
    end
    push(4, 0, 5, 6, ZH, ZH);
    expect_out("R3 full releases while accepting", 1'b1, 4, 10, 0, 0);
    @(posedge clk); @(negedge clk);
    expect_out("R3 R2 pushed report kept and released", 1'b1, 4, 5, 0, 0);
    @(posedge clk); @(negedge clk);
    expect_out("R3 below full stops", 1'b0, 0, 0, 0, 0);
    for (int i = 2; i <= 8; i++) begin
      pop1();
      expect_out("R2 drain order", 1'b1, 4, 16'(i * 10), 0, 0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; flush = 1'b0; in_excl = 1'b0;
    in_block = '0; in_start = '0; in_end = '0; in_start_hash = '0; in_end_hash = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_handoff();
    t_overlap();
    t_sort();
    t_full();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule